// File: doc/BRIEF.md
# Fault-Hardened Integer Register File

A multi-ported integer register file for a processor pipeline: one synchronous write port and two combinational read ports. It is built so that a single fault-induced bit flip in the read path cannot quietly return the wrong register. Each read address is expanded into a one-hot select vector. A checker confirms that exactly one bit of that vector is set. The stored word is then picked by an AND-OR network, not by a binary-indexed multiplexer. A corrupted select therefore raises an alert and never silently steers another register's contents to the port.

Every stored word carries check bits. These are computed when the word is written and recomputed from the data half when the word is read. A mismatch on either read port raises the same alert. The alert is a single registered output that the surrounding chip treats as fatal. Register 0 is hardwired to zero.

Top module: `rf_fh_regfile`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, alert_o is 0, and every register reads 0 on both ports.
- R2: When wr_en_i is 1 on a rising clock edge and wr_addr_i is not 0, wr_data_i is stored in that register and is returned by any read port addressing it from then on.
- R3: Register 0 always reads 0, and a write addressed to it leaves it reading 0.
- R4: Reads are combinational, and a read of the register being written in the same cycle returns the value held before that edge.
- R5: The two read ports are independent, so different addresses on A and B return their own registers in the same cycle.
- R6: If a read select vector has no bit set, alert_o is 1 after the next rising edge.
- R7: If a read select vector has two or more bits set, alert_o is 1 after the next rising edge.
- R8: A stored word is {check[6:0], data[31:0]}. For k in 0..5, check[k] is the XOR of every data bit i where bit k of (i+1) is 1, and check[6] is the XOR of all data bits. A read word whose check bits disagree with its data sets alert_o after the next rising edge.
- R9: alert_o is a registered OR of the four fault sources: select faults and integrity faults on ports A and B. It is 0 on the edge after every source clears, and it stays 0 during normal reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register index |
| wr_data_i | input | 32 | Write data |
| rd_addr_a_i | input | 5 | Port A read register index |
| rd_data_a_o | output | 32 | Port A read data |
| rd_addr_b_i | input | 5 | Port B read register index |
| rd_data_b_o | output | 32 | Port B read data |
| alert_o | output | 1 | Registered fatal fault alert |

## Verification
The bench builds the block with its defaults: 32 registers of 32 data bits with 7 check bits. This makes the full select width, including register 0 and the top index, reachable by directed addresses. It injects faults by forcing the port A select vector to all-zero and to two-hot patterns, and by forcing the read word to a value whose data bit or check bit has been flipped against the bench's own encoding. This covers both alert sources and their clearing.

// File: rtl/rf_fh_pkg.sv
package rf_fh_pkg;
  localparam int unsigned RF_NUM_REGS = 32;
  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_CHECK_W  = 7;

  typedef struct packed {
    logic sel_a;
    logic sel_b;
    logic int_a;
    logic int_b;
  } rf_fault_t;
endpackage

// File: rtl/rf_ecc_enc.sv
module rf_ecc_enc #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHECK_W = 7
) (
  input  logic [DATA_W-1:0]  data_i,
  output logic [CHECK_W-1:0] chk_o
);
  // low bits: positional parity over (i+1); top bit: overall parity
  always_comb begin
    chk_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      for (int k = 0; k < int'(CHECK_W) - 1; k++) begin
        if ((((i + 1) >> k) & 1) != 0) chk_o[k] = chk_o[k] ^ data_i[i];
      end
      chk_o[CHECK_W-1] = chk_o[CHECK_W-1] ^ data_i[i];
    end
  end
endmodule

// File: rtl/rf_sel_dec.sv
module rf_sel_dec #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : gen_dec
    assign sel_o[r] = (addr_i == ADDR_W'(r));
  end
endmodule

// File: rtl/rf_sel_chk.sv
module rf_sel_chk #(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic [NUM_REGS-1:0] sel_i,
  output logic                err_o
);
  logic seen, multi;

  always_comb begin
    seen  = 1'b0;
    multi = 1'b0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      multi = multi | (seen & sel_i[r]);
      seen  = seen | sel_i[r];
    end
    err_o = ~seen | multi;
  end
endmodule

// File: rtl/rf_ohmux.sv
module rf_ohmux #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned WORD_W   = 39
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] words_i,
  input  logic [NUM_REGS-1:0]             sel_i,
  output logic [WORD_W-1:0]               word_o
);
  always_comb begin
    word_o = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      word_o = word_o | (words_i[r] & {WORD_W{sel_i[r]}});
    end
  end
endmodule

// File: rtl/rf_fh_regfile.sv
module rf_fh_regfile
  import rf_fh_pkg::*;
#(
  parameter int unsigned NUM_REGS = RF_NUM_REGS,
  parameter int unsigned DATA_W   = RF_DATA_W,
  parameter int unsigned CHECK_W  = RF_CHECK_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned WORD_W  = DATA_W + CHECK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  output logic              alert_o
);
  logic [CHECK_W-1:0]             wr_chk;
  logic [NUM_REGS-1:0][WORD_W-1:0] words;
  logic [NUM_REGS-1:0]            sel_a, sel_b;
  logic [WORD_W-1:0]              raw_a, raw_b;
  logic [CHECK_W-1:0]             exp_chk_a, exp_chk_b;
  rf_fault_t                      fault;
  logic                           alert_q;

  rf_ecc_enc #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc_wr (
    .data_i(wr_data_i), .chk_o(wr_chk)
  );

  // storage; entry 0 is constant zero (a valid codeword)
  for (genvar r = 0; r < NUM_REGS; r++) begin : gen_reg
    if (r == 0) begin : gen_zero
      assign words[r] = '0;
    end else begin : gen_flop
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_en_i && (wr_addr_i == ADDR_W'(r))) q <= {wr_chk, wr_data_i};
      end
      assign words[r] = q;
    end
  end

  rf_sel_dec #(.NUM_REGS(NUM_REGS)) u_dec_a (.addr_i(rd_addr_a_i), .sel_o(sel_a));
  rf_sel_dec #(.NUM_REGS(NUM_REGS)) u_dec_b (.addr_i(rd_addr_b_i), .sel_o(sel_b));

  rf_sel_chk #(.NUM_REGS(NUM_REGS)) u_chk_a (.sel_i(sel_a), .err_o(fault.sel_a));
  rf_sel_chk #(.NUM_REGS(NUM_REGS)) u_chk_b (.sel_i(sel_b), .err_o(fault.sel_b));

  rf_ohmux #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_mux_a (
    .words_i(words), .sel_i(sel_a), .word_o(raw_a)
  );
  rf_ohmux #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_mux_b (
    .words_i(words), .sel_i(sel_b), .word_o(raw_b)
  );

  rf_ecc_enc #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc_a (
    .data_i(raw_a[DATA_W-1:0]), .chk_o(exp_chk_a)
  );
  rf_ecc_enc #(.DATA_W(DATA_W), .CHECK_W(CHECK_W)) u_enc_b (
    .data_i(raw_b[DATA_W-1:0]), .chk_o(exp_chk_b)
  );

  assign fault.int_a = (exp_chk_a != raw_a[WORD_W-1:DATA_W]);
  assign fault.int_b = (exp_chk_b != raw_b[WORD_W-1:DATA_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= |fault;
  end

  assign rd_data_a_o = raw_a[DATA_W-1:0];
  assign rd_data_b_o = raw_b[DATA_W-1:0];
  assign alert_o     = alert_q;
endmodule

// File: rtl/rf_fh_regfile_chk.sv
module rf_fh_regfile_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WORD_W   = 39,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [ADDR_W-1:0]   rd_addr_a_i,
  input logic [DATA_W-1:0]   rd_data_a_o,
  input logic [ADDR_W-1:0]   rd_addr_b_i,
  input logic [DATA_W-1:0]   rd_data_b_o,
  input logic [NUM_REGS-1:0] sel_a,
  input logic [NUM_REGS-1:0] sel_b,
  input logic                int_err_a,
  input logic                int_err_b,
  input logic                alert_o
);
  // R3
  x0_zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0 && $countones(sel_a) == 1 && !int_err_a) |-> rd_data_a_o == '0);

  // R3
  x0_zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0 && $countones(sel_b) == 1 && !int_err_b) |-> rd_data_b_o == '0);

  // R2
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=>
      (rd_addr_b_i != $past(wr_addr_i) || $countones(sel_b) != 1 || int_err_b ||
       rd_data_b_o == $past(wr_data_i)));

  // R6
  sel_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a == '0 || sel_b == '0) |=> alert_o);

  // R7
  sel_multi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_a) > 1 || $countones(sel_b) > 1) |=> alert_o);

  // R8
  int_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_err_a || int_err_b) |=> alert_o);

  // R9
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_a) == 1 && $countones(sel_b) == 1 && !int_err_a && !int_err_b)
      |=> !alert_o);
endmodule

bind rf_fh_regfile rf_fh_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WORD_W(WORD_W)
) u_rf_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
  .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o), .sel_a(sel_a), .sel_b(sel_b),
  .int_err_a(fault.int_a), .int_err_b(fault.int_b), .alert_o(alert_o)
);

// File: tb/sim_rf_fh_regfile.sv
module sim_rf_fh_regfile;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int CW   = 7;
  localparam int AW   = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_a_i = '0;
  logic [DW-1:0] rd_data_a_o;
  logic [AW-1:0] rd_addr_b_i = '0;
  logic [DW-1:0] rd_data_b_o;
  logic          alert_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  rf_fh_regfile u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
    .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o), .alert_o(alert_o)
  );

  function automatic logic [CW-1:0] code_of(logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) begin
      for (int k = 0; k < CW - 1; k++)
        if ((((i + 1) >> k) & 1) != 0) c[k] ^= d[i];
      c[CW-1] ^= d[i];
    end
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    rd_addr_a_i = 5'd9; rd_addr_b_i = 5'd31;
    #1;
    check("R1 alert in reset", 64'(alert_o), 64'd0);
    check("R1 port A in reset", 64'(rd_data_a_o), 64'd0);
    check("R1 port B in reset", 64'(rd_data_b_o), 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 alert after reset", 64'(alert_o), 64'd0);
  endtask

  task automatic t_write_read;
    wr(1, 32'hDEAD_BEEF);
    wr(31, 32'h8000_0001);
    wr(17, 32'h0000_0000);
    rd_addr_a_i = 5'd1; rd_addr_b_i = 5'd31; #1;
    check("R2 reg1 on A", 64'(rd_data_a_o), 64'hDEAD_BEEF);
    check("R2 reg31 on B", 64'(rd_data_b_o), 64'h8000_0001);
    rd_addr_a_i = 5'd17; rd_addr_b_i = 5'd1; #1;
    check("R2 reg17 on A", 64'(rd_data_a_o), 64'd0);
    check("R2 reg1 on B", 64'(rd_data_b_o), 64'hDEAD_BEEF);
  endtask

  task automatic t_x0;
    wr(0, 32'hFFFF_FFFF);
    rd_addr_a_i = 5'd0; rd_addr_b_i = 5'd0; #1;
    check("R3 x0 on A", 64'(rd_data_a_o), 64'd0);
    check("R3 x0 on B", 64'(rd_data_b_o), 64'd0);
    @(negedge clk_i);
    check("R3 no alert on x0", 64'(alert_o), 64'd0);
  endtask

  task automatic t_rdw;
    wr(5, 32'h1111_2222);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd5; wr_data_i = 32'h3333_4444;
    rd_addr_a_i = 5'd5; rd_addr_b_i = 5'd5; #1;
    check("R4 old value on A", 64'(rd_data_a_o), 64'h1111_2222);
    check("R4 old value on B", 64'(rd_data_b_o), 64'h1111_2222);
    @(negedge clk_i);
    wr_en_i = 1'b0; #1;
    check("R4 new value after edge", 64'(rd_data_a_o), 64'h3333_4444);
  endtask

  task automatic t_ports;
    for (int i = 2; i < 8; i++) wr(i + 8, DW'(32'hA5A5_0000 + 32'(i * 7)));
    for (int i = 2; i < 8; i++) begin
      rd_addr_a_i = AW'(i + 8); rd_addr_b_i = AW'(17 - i); #1;
      check("R5 port A independent", 64'(rd_data_a_o), 64'(32'hA5A5_0000 + 32'(i * 7)));
      check("R5 port B independent", 64'(rd_data_b_o), 64'(32'hA5A5_0000 + 32'((9 - i) * 7)));
    end
  endtask

  task automatic t_sel_zero;
    @(negedge clk_i);
    rd_addr_a_i = 5'd1; rd_addr_b_i = 5'd2;
    force u0.sel_a = '0;
    @(negedge clk_i);
    check("R6 empty select alert", 64'(alert_o), 64'd1);
    release u0.sel_a;
    @(negedge clk_i);
    check("R9 alert clears after empty select", 64'(alert_o), 64'd0);
  endtask

  task automatic t_sel_twohot;
    @(negedge clk_i);
    force u0.sel_a = 32'h0000_0028;
    @(negedge clk_i);
    check("R7 two-hot select alert", 64'(alert_o), 64'd1);
    force u0.sel_a = 32'h8000_0001;
    @(negedge clk_i);
    check("R7 two-hot with x0 alert", 64'(alert_o), 64'd1);
    release u0.sel_a;
    @(negedge clk_i);
    check("R9 alert clears after two-hot", 64'(alert_o), 64'd0);
  endtask

  task automatic t_int_flip;
    logic [DW-1:0] d = 32'h0F0F_1234;
    wr(7, d);
    rd_addr_a_i = 5'd7; #1;
    check("R8 clean read", 64'(rd_data_a_o), 64'(d));
    @(negedge clk_i);
    check("R8 clean read no alert", 64'(alert_o), 64'd0);
    force u0.raw_a = {code_of(d), d ^ 32'h0000_0010};
    @(negedge clk_i);
    check("R8 data bit flip alert", 64'(alert_o), 64'd1);
    force u0.raw_a = {code_of(d) ^ 7'h40, d};
    @(negedge clk_i);
    check("R8 check bit flip alert", 64'(alert_o), 64'd1);
    force u0.raw_a = {code_of(32'hCAFE_0001), 32'hCAFE_0001};
    @(negedge clk_i);
    check("R8 valid codeword no alert", 64'(alert_o), 64'd0);
    release u0.raw_a;
    @(negedge clk_i);
    check("R9 alert quiet after release", 64'(alert_o), 64'd0);
  endtask

  task automatic t_quiet;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = AW'(i + 20); wr_data_i = DW'(i * 32'h0101_0101);
      rd_addr_a_i = AW'(i + 19); rd_addr_b_i = AW'(i);
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R9 no alert in normal traffic", 64'(alert_o), 64'd0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_x0();
    t_rdw();
    t_ports();
    t_sel_zero();
    t_sel_twohot();
    t_int_flip();
    t_quiet();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule